// File: doc/BRIEF.md
# Rotating Bank-Group Slot Selector

This block sits in front of a fixed-service memory scheduler for a memory shared by several security domains with no partitioning. Time is cut into equal slots; in each slot exactly one domain owns the data bus, and the owner rotates through the domains in a fixed order. To keep the slot short, the slot's bank eligibility also rotates: banks are sorted into three groups by their number modulo three ({0,3,6}, {1,4,7}, {2,5}). Slot n may only serve the group n mod 3. A bank can therefore be touched at most once in any three consecutive slots. With a 15-cycle slot this spaces reuse of a bank by at least 45 cycles, which covers the 43-cycle same-bank recovery time. The slot stays at 15 cycles rather than the 43 a slot would need if any bank could be hit.

Each domain has a small request queue whose entries are tagged with a bank number. At the start of every slot the selector looks at the owning domain's queue and takes its oldest request whose bank falls in the slot's group. If the domain has no such request, it issues a dummy access to a bank of that group, so the bus pattern never depends on what the domains are doing. Command timing and the DRAM model are outside this block.

The control is a two-state machine. `SLOT_ISSUE` lasts one cycle and is where the pick is made. `SLOT_HOLD` covers the remaining `SLOT_CYCLES-1` cycles of the slot. The transitions are ISSUE→HOLD (always), HOLD→HOLD (slot cycle count below `SLOT_CYCLES-1`), and HOLD→ISSUE (last cycle of the slot). The HOLD→ISSUE transition advances the group and domain pointers.

Top module: `tas_slot_selector`

## Requirements
- R1: While `rst` is high, `grant_valid` is 0. Reset leaves the machine in `SLOT_ISSUE` with group 0 and domain 0, so the first grant after reset shows `grant_group`=0 and `grant_domain`=0 and is valid one cycle after `rst` falls.
- R2: `grant_valid` is a one-cycle pulse that repeats exactly every `SLOT_CYCLES` cycles.
- R3: `grant_group` steps by one on each successive grant and wraps from `NUM_GROUPS-1` to 0.
- R4: `grant_domain` steps by one on each successive grant and wraps from `NUM_DOMAINS-1` to 0.
- R5: A non-dummy grant comes only from the domain shown in `grant_domain`, and its `grant_bank` satisfies bank mod `NUM_GROUPS` == `grant_group`.
- R6: Among the owning domain's queued requests in the slot's group, the one pushed earliest is granted. `grant_tag` carries the tag it was pushed with, and the entry leaves the queue.
- R7: If the owning domain holds no request for the slot's group, the grant has `grant_dummy`=1, `grant_bank` equal to the group index (the lowest bank of that group) and `grant_tag`=0.
- R8: Each domain queue holds `QUEUE_DEPTH` requests. `req_full[d]` is 1 exactly when it holds that many, and a push to a full queue is dropped: that request is never granted.
- R9: Two grants to the same bank, dummy grants included, are at least `NUM_GROUPS` slots apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_DOMAINS | Push strobe, one bit per domain |
| req_bank | input | NUM_DOMAINS*BANK_W | Bank of each pushed request, domain d at bits [d*BANK_W +: BANK_W] |
| req_tag | input | NUM_DOMAINS*TAG_W | Tag of each pushed request, domain d at bits [d*TAG_W +: TAG_W] |
| req_full | output | NUM_DOMAINS | Queue of domain d holds QUEUE_DEPTH requests |
| grant_valid | output | 1 | One-cycle pulse carrying the slot's selection |
| grant_dummy | output | 1 | Selection is a dummy access |
| grant_domain | output | DOM_W | Owning domain of the slot |
| grant_group | output | GRP_W | Bank group of the slot |
| grant_bank | output | BANK_W | Bank accessed in the slot |
| grant_tag | output | TAG_W | Tag of the granted request, 0 for a dummy |

## Verification
The bench builds the selector with two domains, a three-entry queue per domain, eight banks in three groups and a four-cycle slot. With these values the six-slot joint cycle of domain and group repeats every 24 cycles. Every bank can then be pushed into every domain within a short run, and a queue fills and overflows within a few slots. A reference model in the bench computes the owner, group, oldest eligible request and dummy bank for each slot arithmetically. Besides that sweep, the bench runs an idle stretch, a stretch of same-group requests that checks age order, an overflow burst, and a long pseudo-random stretch.

// File: rtl/tas_pkg.sv
package tas_pkg;

    typedef enum logic [0:0] {
        SLOT_ISSUE = 1'b0,
        SLOT_HOLD  = 1'b1
    } slot_state_e;

    // Group that a bank belongs to under modulo grouping.
    function automatic int unsigned bank_group(int unsigned bank, int unsigned groups);
        return bank % groups;
    endfunction

endpackage

// File: rtl/tas_oldest_pick.sv
module tas_oldest_pick #(
    parameter int DEPTH      = 4,
    parameter int BANK_W     = 3,
    parameter int NUM_GROUPS = 3,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]        entry_valid,
    input  logic [DEPTH*BANK_W-1:0] entry_bank,
    input  logic [GRP_W-1:0]        group,
    output logic                    found,
    output logic [IDX_W-1:0]        found_idx
);

    logic [DEPTH-1:0] eligible;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_elig
            assign eligible[i] = entry_valid[i] &&
                (GRP_W'(tas_pkg::bank_group(32'(entry_bank[i*BANK_W +: BANK_W]), NUM_GROUPS)) == group);
        end
    endgenerate

    // Entry 0 is the oldest; the lowest eligible index wins.
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found     = 1'b1;
                found_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tas_req_queue.sv
module tas_req_queue #(
    parameter int DEPTH      = 4,
    parameter int BANK_W     = 3,
    parameter int TAG_W      = 8,
    parameter int NUM_GROUPS = 3,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [GRP_W-1:0]  group,
    input  logic              take,
    output logic              hit,
    output logic [BANK_W-1:0] hit_bank,
    output logic [TAG_W-1:0]  hit_tag,
    output logic              full
);

    logic [BANK_W-1:0] q_bank [DEPTH];
    logic [TAG_W-1:0]  q_tag  [DEPTH];
    logic [CNT_W-1:0]  cnt_q;

    logic [BANK_W-1:0] n_bank [DEPTH];
    logic [TAG_W-1:0]  n_tag  [DEPTH];
    logic [CNT_W-1:0]  n_cnt;

    logic [DEPTH-1:0]        valid_vec;
    logic [DEPTH*BANK_W-1:0] bank_flat;
    logic [IDX_W-1:0]        pick_idx;
    logic                    pick_found;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_flat
            assign valid_vec[i]                    = (CNT_W'(i) < cnt_q);
            assign bank_flat[i*BANK_W +: BANK_W]   = q_bank[i];
        end
    endgenerate

    tas_oldest_pick #(
        .DEPTH      (DEPTH),
        .BANK_W     (BANK_W),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_pick (
        .entry_valid (valid_vec),
        .entry_bank  (bank_flat),
        .group       (group),
        .found       (pick_found),
        .found_idx   (pick_idx)
    );

    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign hit      = pick_found;
    assign hit_bank = q_bank[pick_idx];
    assign hit_tag  = q_tag[pick_idx];

    // Removal closes the gap by shifting younger entries down, which
    // keeps index order equal to age order; a push lands on the tail.
    always_comb begin
        n_bank = q_bank;
        n_tag  = q_tag;
        n_cnt  = cnt_q;
        if (take && pick_found) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pick_idx) begin
                    n_bank[i] = q_bank[i+1];
                    n_tag[i]  = q_tag[i+1];
                end
            end
            n_cnt = cnt_q - CNT_W'(1);
        end
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == n_cnt) begin
                    n_bank[i] = push_bank;
                    n_tag[i]  = push_tag;
                end
            end
            n_cnt = n_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= n_cnt;
        end
    end

    always_ff @(posedge clk) begin
        q_bank <= n_bank;
        q_tag  <= n_tag;
    end

endmodule

// File: rtl/tas_slot_fsm.sv
module tas_slot_fsm #(
    parameter int SLOT_CYCLES = 15,
    parameter int NUM_GROUPS  = 3,
    parameter int NUM_DOMAINS = 4,
    localparam int CNT_W      = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1,
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             slot_issue,
    output logic [GRP_W-1:0] cur_group,
    output logic [DOM_W-1:0] cur_domain
);

    import tas_pkg::*;

    slot_state_e      state_q, state_n;
    logic [CNT_W-1:0] cyc_q;
    logic [GRP_W-1:0] group_q;
    logic [DOM_W-1:0] dom_q;
    logic             advance;

    // Next state.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SLOT_ISSUE: state_n = SLOT_HOLD;
            SLOT_HOLD:  state_n = (cyc_q == CNT_W'(SLOT_CYCLES - 1)) ? SLOT_ISSUE : SLOT_HOLD;
            default:    state_n = SLOT_ISSUE;
        endcase
    end

    assign advance = (state_q == SLOT_HOLD) && (state_n == SLOT_ISSUE);

    // State register with slot cycle count and rotation pointers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_ISSUE;
            cyc_q   <= '0;
            group_q <= '0;
            dom_q   <= '0;
        end else begin
            state_q <= state_n;
            cyc_q   <= (state_n == SLOT_ISSUE) ? '0 : cyc_q + CNT_W'(1);
            if (advance) begin
                group_q <= (group_q == GRP_W'(NUM_GROUPS - 1)) ? '0 : group_q + GRP_W'(1);
                dom_q   <= (dom_q == DOM_W'(NUM_DOMAINS - 1)) ? '0 : dom_q + DOM_W'(1);
            end
        end
    end

    // Outputs.
    always_comb begin
        slot_issue = 1'b0;
        unique case (state_q)
            SLOT_ISSUE: slot_issue = 1'b1;
            SLOT_HOLD:  slot_issue = 1'b0;
            default:    slot_issue = 1'b0;
        endcase
        cur_group  = group_q;
        cur_domain = dom_q;
    end

endmodule

// File: rtl/tas_slot_selector.sv
module tas_slot_selector #(
    parameter int NUM_DOMAINS = 4,
    parameter int NUM_BANKS   = 8,
    parameter int NUM_GROUPS  = 3,
    parameter int QUEUE_DEPTH = 4,
    parameter int SLOT_CYCLES = 15,
    parameter int TAG_W       = 8,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_DOMAINS-1:0]        req_valid,
    input  logic [NUM_DOMAINS*BANK_W-1:0] req_bank,
    input  logic [NUM_DOMAINS*TAG_W-1:0]  req_tag,
    output logic [NUM_DOMAINS-1:0]        req_full,
    output logic                          grant_valid,
    output logic                          grant_dummy,
    output logic [DOM_W-1:0]              grant_domain,
    output logic [GRP_W-1:0]              grant_group,
    output logic [BANK_W-1:0]             grant_bank,
    output logic [TAG_W-1:0]              grant_tag
);

    logic             slot_issue;
    logic [GRP_W-1:0] cur_group;
    logic [DOM_W-1:0] cur_domain;

    logic [NUM_DOMAINS-1:0] q_hit;
    logic [BANK_W-1:0]      q_bank [NUM_DOMAINS];
    logic [TAG_W-1:0]       q_tag  [NUM_DOMAINS];

    logic              sel_hit;
    logic [BANK_W-1:0] sel_bank;
    logic [TAG_W-1:0]  sel_tag;

    tas_slot_fsm #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .NUM_GROUPS  (NUM_GROUPS),
        .NUM_DOMAINS (NUM_DOMAINS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .slot_issue (slot_issue),
        .cur_group  (cur_group),
        .cur_domain (cur_domain)
    );

    generate
        for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
            tas_req_queue #(
                .DEPTH      (QUEUE_DEPTH),
                .BANK_W     (BANK_W),
                .TAG_W      (TAG_W),
                .NUM_GROUPS (NUM_GROUPS)
            ) u_queue (
                .clk       (clk),
                .rst       (rst),
                .push      (req_valid[d]),
                .push_bank (req_bank[d*BANK_W +: BANK_W]),
                .push_tag  (req_tag[d*TAG_W +: TAG_W]),
                .group     (cur_group),
                .take      (slot_issue && (cur_domain == DOM_W'(d))),
                .hit       (q_hit[d]),
                .hit_bank  (q_bank[d]),
                .hit_tag   (q_tag[d]),
                .full      (req_full[d])
            );
        end
    endgenerate

    // Only the owning domain's queue is looked at.
    always_comb begin
        sel_hit  = 1'b0;
        sel_bank = '0;
        sel_tag  = '0;
        for (int d = 0; d < NUM_DOMAINS; d++) begin
            if (cur_domain == DOM_W'(d)) begin
                sel_hit  = q_hit[d];
                sel_bank = q_bank[d];
                sel_tag  = q_tag[d];
            end
        end
    end

    // The group index is also the lowest bank of the group: dummy target.
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid  <= 1'b0;
            grant_dummy  <= 1'b0;
            grant_domain <= '0;
            grant_group  <= '0;
            grant_bank   <= '0;
            grant_tag    <= '0;
        end else begin
            grant_valid <= slot_issue;
            if (slot_issue) begin
                grant_dummy  <= !sel_hit;
                grant_domain <= cur_domain;
                grant_group  <= cur_group;
                grant_bank   <= sel_hit ? sel_bank : BANK_W'(cur_group);
                grant_tag    <= sel_hit ? sel_tag : '0;
            end
        end
    end

endmodule

// File: rtl/tas_slot_checker.sv
module tas_slot_checker #(
    parameter int NUM_DOMAINS = 4,
    parameter int NUM_BANKS   = 8,
    parameter int NUM_GROUPS  = 3,
    parameter int SLOT_CYCLES = 15,
    parameter int TAG_W       = 8,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int DOM_W      = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              grant_valid,
    input logic              grant_dummy,
    input logic [DOM_W-1:0]  grant_domain,
    input logic [GRP_W-1:0]  grant_group,
    input logic [BANK_W-1:0] grant_bank,
    input logic [TAG_W-1:0]  grant_tag
);

    logic             rst_d = 1'b0;
    logic             seen;
    logic [GRP_W-1:0] prev_group;
    logic [DOM_W-1:0] prev_domain;
    logic [31:0]      slot_no;
    logic [31:0]      last_use [NUM_BANKS];
    logic [NUM_BANKS-1:0] used;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            seen        <= 1'b0;
            prev_group  <= '0;
            prev_domain <= '0;
            slot_no     <= '0;
            used        <= '0;
        end else if (grant_valid) begin
            seen        <= 1'b1;
            prev_group  <= grant_group;
            prev_domain <= grant_domain;
            slot_no     <= slot_no + 32'd1;
            used[grant_bank]     <= 1'b1;
            last_use[grant_bank] <= slot_no;
        end
    end

    // R1: grant_valid stays low through the cycle after a reset edge
    always @(posedge clk) begin
        if (rst_d) begin
            assert_reset_quiet_R1: assert (!grant_valid);
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> !grant_valid);

    assert_group_step_R3: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && seen) |->
            (grant_group == ((prev_group == GRP_W'(NUM_GROUPS - 1)) ? '0 : prev_group + GRP_W'(1))));

    assert_domain_step_R4: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && seen) |->
            (grant_domain == ((prev_domain == DOM_W'(NUM_DOMAINS - 1)) ? '0 : prev_domain + DOM_W'(1))));

    assert_first_slot_R1: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !seen) |-> (grant_group == '0 && grant_domain == '0));

    assert_bank_in_group_R5: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !grant_dummy) |->
            ((32'(grant_bank) % NUM_GROUPS) == 32'(grant_group)));

    assert_dummy_target_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_dummy) |->
            (32'(grant_bank) == 32'(grant_group) && grant_tag == '0));

    assert_bank_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && used[grant_bank]) |->
            ((slot_no - last_use[grant_bank]) >= 32'(NUM_GROUPS)));

endmodule

bind tas_slot_selector tas_slot_checker #(
    .NUM_DOMAINS (NUM_DOMAINS),
    .NUM_BANKS   (NUM_BANKS),
    .NUM_GROUPS  (NUM_GROUPS),
    .SLOT_CYCLES (SLOT_CYCLES),
    .TAG_W       (TAG_W)
) u_slot_checker (
    .clk          (clk),
    .rst          (rst),
    .grant_valid  (grant_valid),
    .grant_dummy  (grant_dummy),
    .grant_domain (grant_domain),
    .grant_group  (grant_group),
    .grant_bank   (grant_bank),
    .grant_tag    (grant_tag)
);

// File: tb/tb_tas_slot_selector.sv
module tb_tas_slot_selector;

    localparam int ND    = 2;
    localparam int NB    = 8;
    localparam int NG    = 3;
    localparam int DEPTH = 3;
    localparam int SLOT  = 4;
    localparam int TW    = 8;
    localparam int BW    = 3;
    localparam int GW    = 2;
    localparam int DW    = 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ND-1:0]     req_valid = '0;
    logic [ND*BW-1:0]  req_bank  = '0;
    logic [ND*TW-1:0]  req_tag   = '0;
    logic [ND-1:0]     req_full;
    logic              grant_valid;
    logic              grant_dummy;
    logic [DW-1:0]     grant_domain;
    logic [GW-1:0]     grant_group;
    logic [BW-1:0]     grant_bank;
    logic [TW-1:0]     grant_tag;

    always #10 clk = ~clk;

    tas_slot_selector #(
        .NUM_DOMAINS (ND),
        .NUM_BANKS   (NB),
        .NUM_GROUPS  (NG),
        .QUEUE_DEPTH (DEPTH),
        .SLOT_CYCLES (SLOT),
        .TAG_W       (TW)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_bank     (req_bank),
        .req_tag      (req_tag),
        .req_full     (req_full),
        .grant_valid  (grant_valid),
        .grant_dummy  (grant_dummy),
        .grant_domain (grant_domain),
        .grant_group  (grant_group),
        .grant_bank   (grant_bank),
        .grant_tag    (grant_tag)
    );

    int total = 0;
    int bad   = 0;
    bit hung  = 0;
    int slot_k = 0;
    int next_tag = 1;
    logic [15:0] lfsr = 16'hACE1;

    int mq_bank [ND][DEPTH];
    int mq_tag  [ND][DEPTH];
    int mq_n    [ND];
    int last_slot [NB];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, slot_k, act, exp);
        end
    endtask

    // Wait for the next grant, check it against the model, then drive pushes.
    task automatic slot_step(input logic [ND-1:0] pv, input int b0, input int b1, input int exp_gap);
        int gap;
        int dom, grp, hit, eb, et;
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            req_valid = '0;
        end while (!grant_valid && gap < 64);
        if (!grant_valid) begin
            hung = 1;
            chk(0, "watchdog", gap, exp_gap);
            return;
        end
        chk(gap == exp_gap, "R2 slot period", gap, exp_gap);
        dom = slot_k % ND;
        grp = slot_k % NG;
        hit = -1;
        for (int i = 0; i < mq_n[dom]; i++)
            if (hit < 0 && (mq_bank[dom][i] % NG) == grp) hit = i;
        eb = (hit < 0) ? grp : mq_bank[dom][hit];
        et = (hit < 0) ? 0 : mq_tag[dom][hit];
        if (hit >= 0) begin
            for (int i = hit; i < mq_n[dom] - 1; i++) begin
                mq_bank[dom][i] = mq_bank[dom][i+1];
                mq_tag[dom][i]  = mq_tag[dom][i+1];
            end
            mq_n[dom]--;
        end
        chk(int'(grant_group) == grp, "R3 group", int'(grant_group), grp);
        chk(int'(grant_domain) == dom, "R4 domain", int'(grant_domain), dom);
        chk(int'(grant_dummy) == (hit < 0 ? 1 : 0), (hit < 0) ? "R7 dummy flag" : "R5 real grant",
            int'(grant_dummy), (hit < 0) ? 1 : 0);
        chk(int'(grant_bank) == eb, (hit < 0) ? "R7 dummy bank" : "R5 bank", int'(grant_bank), eb);
        chk(int'(grant_tag) == et, (hit < 0) ? "R7 dummy tag" : "R6 oldest tag", int'(grant_tag), et);
        if (last_slot[eb] >= 0)
            chk(slot_k - last_slot[eb] >= NG, "R9 bank spacing", slot_k - last_slot[eb], NG);
        last_slot[eb] = slot_k;
        for (int d = 0; d < ND; d++)
            chk(req_full[d] == (mq_n[d] == DEPTH), "R8 full flag", int'(req_full[d]),
                (mq_n[d] == DEPTH) ? 1 : 0);
        slot_k++;
        // pushes land at the next edge, well before the next slot start
        for (int d = 0; d < ND; d++) begin
            if (pv[d]) begin
                req_bank[d*BW +: BW] = BW'((d == 0) ? b0 : b1);
                req_tag[d*TW +: TW]  = TW'(next_tag);
                if (mq_n[d] < DEPTH) begin
                    mq_bank[d][mq_n[d]] = (d == 0) ? b0 : b1;
                    mq_tag[d][mq_n[d]]  = next_tag & 8'hFF;
                    mq_n[d]++;
                end
                next_tag = (next_tag == 255) ? 1 : next_tag + 1;
            end
        end
        req_valid = pv;
    endtask

    initial begin
        for (int d = 0; d < ND; d++) mq_n[d] = 0;
        for (int b = 0; b < NB; b++) last_slot[b] = -1;

        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            chk(grant_valid == 1'b0, "R1 valid low in reset", int'(grant_valid), 0);
        end
        rst = 1'b0;

        // R1: first grant one cycle after release, group 0 domain 0; idle gives R7 dummies
        slot_step('0, 0, 0, 1);
        for (int i = 0; i < 6 && !hung; i++) slot_step('0, 0, 0, SLOT);

        // R5: sweep every bank into every domain
        for (int d = 0; d < ND && !hung; d++)
            for (int b = 0; b < NB && !hung; b++)
                slot_step(ND'(1 << d), b, b, SLOT);
        for (int i = 0; i < 12 && !hung; i++) slot_step('0, 0, 0, SLOT);

        // R6: several same-group entries in one queue, served oldest first
        slot_step(2'b01, 3, 0, SLOT);
        slot_step(2'b01, 6, 0, SLOT);
        slot_step(2'b01, 0, 0, SLOT);
        for (int i = 0; i < 12 && !hung; i++) slot_step('0, 0, 0, SLOT);

        // R8: overflow both queues with group-2 banks
        for (int i = 0; i < 8 && !hung; i++) slot_step(2'b11, (i % 2) ? 5 : 2, 2, SLOT);
        for (int i = 0; i < 20 && !hung; i++) slot_step('0, 0, 0, SLOT);

        // Mixed pseudo-random traffic
        for (int i = 0; i < 200 && !hung; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            slot_step(lfsr[1:0], int'(lfsr[4:2]), int'(lfsr[7:5]), SLOT);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule